// File: doc/BRIEF.md
# Programmable-Resolution Time Tag Counter

This block keeps a 16-bit time tag that stamps bus messages. In normal use it advances from an internal timebase: a one-microsecond strobe from elsewhere on the chip is divided by a power of two, chosen by a resolution select, so the counter's least significant bit is worth 2, 4, 8, 16, 32 or 64 microseconds. Two other count sources can replace the timebase. One is an external tag clock input, which is synchronised and edge-detected. The other is a step mode for self-test, where the counter moves only when software issues a step command.

The host can load the counter at any time. The protocol engine can clear it when a synchronize-without-data command arrives, or load it from the received data word when a synchronize-with-data command arrives. Each of these two actions has its own enable. A reset command clears both the counter and the prescaler. When an advance carries the counter from FFFF to 0000, a sticky rollover flag is set, and this flag can drive an interrupt request. A start-of-message or end-of-message strobe copies the present counter value into a snapshot register. The stack logic then takes the stamp from that register.

Top module: `timeTagCounter`

## Requirements
- R1: After reset, tagValue, snapValue, rollFlag and rollIrq are all zero.
- R2: With srcSel = 0 (internal), the counter gains one for every 2^(resSel+1) cycles in which usStrobe is high. resSel values 6 and 7 behave as 5, which gives 64 pulses per count. The prescaler restarts from zero after reset and after swClear.
- R3: With srcSel = 2 or 3 (step), each cycle with swStep high adds one, and usStrobe has no effect. With srcSel = 0 or 1, swStep has no effect.
- R4: With srcSel = 1 (external), each rising edge of extTagClk adds exactly one. The new value appears on the third rising clk edge after extTagClk rises. usStrobe has no effect in this mode.
- R5: When hostWrEn is high, tagValue equals hostWrData after the next edge. This load wins over an advance in the same cycle.
- R6: A syncNoData pulse clears the counter when syncClrEn is 1. When syncClrEn is 0, the pulse has no effect.
- R7: A syncWithData pulse loads syncData when syncLdEn is 1, and this load wins over a host write in the same cycle. When syncLdEn is 0, the pulse has no effect.
- R8: An advance from FFFF to 0000 sets rollFlag. A host load of any value does not set it. The flag stays set until rollAck is high, and setting wins over rollAck in the same cycle. rollIrq is rollFlag AND rollIrqEn.
- R9: A somStrobe or eomStrobe pulse copies the counter value present in that cycle (before that cycle's update) into snapValue on the next edge.
- R10: swClear zeroes the counter on the next edge. It wins over every other source of change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| usStrobe | input | 1 | One-cycle pulse every microsecond |
| resSel | input | 3 | Resolution select: 2^(resSel+1) us per count |
| srcSel | input | 2 | Count source: 0 internal, 1 external, 2/3 step |
| extTagClk | input | 1 | External tag clock, asynchronous |
| swStep | input | 1 | Software step command |
| swClear | input | 1 | Reset command for counter and prescaler |
| hostWrEn | input | 1 | Host load strobe |
| hostWrData | input | 16 | Host load value |
| syncClrEn | input | 1 | Enables clear on synchronize-without-data |
| syncLdEn | input | 1 | Enables load on synchronize-with-data |
| syncNoData | input | 1 | Synchronize-without-data event |
| syncWithData | input | 1 | Synchronize-with-data event |
| syncData | input | 16 | Data word received with the synchronize command |
| somStrobe | input | 1 | Start-of-message strobe |
| eomStrobe | input | 1 | End-of-message strobe |
| rollAck | input | 1 | Clears the rollover flag |
| rollIrqEn | input | 1 | Enables the rollover interrupt request |
| tagValue | output | 16 | Current counter value |
| snapValue | output | 16 | Value captured at the last message boundary |
| rollFlag | output | 1 | Sticky rollover flag |
| rollIrq | output | 1 | Rollover interrupt request |

## Verification
The internal timebase is driven with pulse counts that fall on both sides of each divisor, from the finest resolution to the two unused select codes. A wrong divisor, a prescaler that is off by one, or a failure to clamp the select would each show up as a different final count. The same microsecond pulses are then sent in the external and step modes, where the count must not move. Step pulses are sent in internal mode for the same reason. Events that collide in one cycle (clear, sync load, host write and advance) are applied in pairs, so that each level of the priority order gives a different result. Rollover is tested by advancing from FFFF, by loading directly, and with the acknowledge arriving in the same cycle as the set.

// File: rtl/ttPkg.sv
package ttPkg;
  typedef struct packed {
    logic clr;
    logic ld;
    logic wr;
    logic adv;
    logic cap;
  } ttCmd_t;

  typedef enum logic [1:0] {
    SRC_INT  = 2'd0,
    SRC_EXT  = 2'd1,
    SRC_STEP = 2'd2,
    SRC_ALT  = 2'd3
  } ttSrc_e;
endpackage

// File: rtl/ttCtrl.sv
module ttCtrl #(
  parameter int SEL_MAX = 5,
  parameter int SEL_W   = 3,
  parameter int SYNC_STAGES = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              usStrobe,
  input  logic [SEL_W-1:0]  resSel,
  input  logic [1:0]        srcSel,
  input  logic              extTagClk,
  input  logic              swStep,
  input  logic              swClear,
  input  logic              hostWrEn,
  input  logic              syncClrEn,
  input  logic              syncLdEn,
  input  logic              syncNoData,
  input  logic              syncWithData,
  input  logic              somStrobe,
  input  logic              eomStrobe,
  output ttPkg::ttCmd_t     cmd
);
  localparam int PRE_W = SEL_MAX + 1;

  logic [SEL_W-1:0]       effSel;
  logic [PRE_W-1:0]       preLimit;
  logic [PRE_W-1:0]       preCnt;
  logic [SYNC_STAGES-1:0] extSync;
  logic                   intTick;
  logic                   extRise;
  logic                   advReq;

  always_comb begin
    effSel = (resSel > SEL_W'(SEL_MAX)) ? SEL_W'(SEL_MAX) : resSel;
    preLimit = '0;
    for (int i = 0; i < PRE_W; i++) begin
      if (i <= int'(effSel)) preLimit[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (swClear) begin
      preCnt <= '0;
    end else if (usStrobe) begin
      if (preCnt >= preLimit) preCnt <= '0;
      else                    preCnt <= preCnt + 1'b1;
    end
  end

  assign intTick = usStrobe && (preCnt >= preLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) extSync <= '0;
    else       extSync <= {extSync[SYNC_STAGES-2:0], extTagClk};
  end

  assign extRise = extSync[SYNC_STAGES-2] && !extSync[SYNC_STAGES-1];

  always_comb begin
    unique case (ttPkg::ttSrc_e'(srcSel))
      ttPkg::SRC_INT: advReq = intTick;
      ttPkg::SRC_EXT: advReq = extRise;
      default:        advReq = swStep;
    endcase
  end

  always_comb begin
    cmd.clr = swClear || (syncNoData && syncClrEn);
    cmd.ld  = !cmd.clr && syncWithData && syncLdEn;
    cmd.wr  = !cmd.clr && !cmd.ld && hostWrEn;
    cmd.adv = !cmd.clr && !cmd.ld && !cmd.wr && advReq;
    cmd.cap = somStrobe || eomStrobe;
  end

  // R2
  int_tick_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.adv && srcSel == 2'd0) |-> usStrobe);

  // R10
  prescale_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    swClear |=> (preCnt == '0));

  // R3
  step_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.adv && srcSel[1]) |-> swStep);
endmodule

// File: rtl/ttDatapath.sv
module ttDatapath #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ttPkg::ttCmd_t    cmd,
  input  logic [CNT_W-1:0] hostWrData,
  input  logic [CNT_W-1:0] syncData,
  input  logic             rollAck,
  output logic [CNT_W-1:0] tagValue,
  output logic [CNT_W-1:0] snapValue,
  output logic             rollFlag
);
  logic atTop;
  assign atTop = &tagValue;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        tagValue <= '0;
    else if (cmd.clr) tagValue <= '0;
    else if (cmd.ld)  tagValue <= syncData;
    else if (cmd.wr)  tagValue <= hostWrData;
    else if (cmd.adv) tagValue <= tagValue + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        snapValue <= '0;
    else if (cmd.cap) snapValue <= tagValue;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  rollFlag <= 1'b0;
    else if (cmd.adv && atTop)  rollFlag <= 1'b1;
    else if (rollAck)           rollFlag <= 1'b0;
  end

  // R10
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clr |=> (tagValue == '0));

  // R7
  sync_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.ld |=> (tagValue == $past(syncData)));

  // R8
  roll_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.adv && atTop) |=> (rollFlag && tagValue == '0));

  // R8
  roll_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rollFlag && !rollAck) |=> rollFlag);

  // R9
  snap_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.cap |=> (snapValue == $past(tagValue)));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cmd.clr || cmd.ld || cmd.wr || cmd.adv) |=> $stable(tagValue));
endmodule

// File: rtl/timeTagCounter.sv
module timeTagCounter #(
  parameter int CNT_W   = 16,
  parameter int SEL_MAX = 5,
  parameter int SEL_W   = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             usStrobe,
  input  logic [SEL_W-1:0] resSel,
  input  logic [1:0]       srcSel,
  input  logic             extTagClk,
  input  logic             swStep,
  input  logic             swClear,
  input  logic             hostWrEn,
  input  logic [CNT_W-1:0] hostWrData,
  input  logic             syncClrEn,
  input  logic             syncLdEn,
  input  logic             syncNoData,
  input  logic             syncWithData,
  input  logic [CNT_W-1:0] syncData,
  input  logic             somStrobe,
  input  logic             eomStrobe,
  input  logic             rollAck,
  input  logic             rollIrqEn,
  output logic [CNT_W-1:0] tagValue,
  output logic [CNT_W-1:0] snapValue,
  output logic             rollFlag,
  output logic             rollIrq
);
  ttPkg::ttCmd_t cmd;

  ttCtrl #(.SEL_MAX(SEL_MAX), .SEL_W(SEL_W), .SYNC_STAGES(3)) uCtrl (
    .clk(clk), .rstN(rstN), .usStrobe(usStrobe), .resSel(resSel),
    .srcSel(srcSel), .extTagClk(extTagClk), .swStep(swStep),
    .swClear(swClear), .hostWrEn(hostWrEn), .syncClrEn(syncClrEn),
    .syncLdEn(syncLdEn), .syncNoData(syncNoData),
    .syncWithData(syncWithData), .somStrobe(somStrobe),
    .eomStrobe(eomStrobe), .cmd(cmd)
  );

  ttDatapath #(.CNT_W(CNT_W)) uData (
    .clk(clk), .rstN(rstN), .cmd(cmd), .hostWrData(hostWrData),
    .syncData(syncData), .rollAck(rollAck), .tagValue(tagValue),
    .snapValue(snapValue), .rollFlag(rollFlag)
  );

  assign rollIrq = rollFlag && rollIrqEn;
endmodule

// File: tb/tb_timeTagCounter.sv
module tb_timeTagCounter;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        usStrobe = 0, extTagClk = 0, swStep = 0, swClear = 0;
  logic [2:0]  resSel = '0;
  logic [1:0]  srcSel = '0;
  logic        hostWrEn = 0, syncClrEn = 0, syncLdEn = 0;
  logic        syncNoData = 0, syncWithData = 0;
  logic [15:0] hostWrData = '0, syncData = '0;
  logic        somStrobe = 0, eomStrobe = 0, rollAck = 0, rollIrqEn = 0;
  logic [15:0] tagValue, snapValue;
  logic        rollFlag, rollIrq;

  int nChecks = 0;
  int nFails  = 0;

  // {resSel, usStrobe pulses, expected count}
  localparam logic [26:0] VEC [8] = '{
    {3'd0, 8'd10,  16'd5},
    {3'd1, 8'd11,  16'd2},
    {3'd2, 8'd23,  16'd2},
    {3'd3, 8'd33,  16'd2},
    {3'd4, 8'd64,  16'd2},
    {3'd5, 8'd127, 16'd1},
    {3'd6, 8'd64,  16'd1},
    {3'd7, 8'd63,  16'd0}
  };

  timeTagCounter dut (
    .clk(clk), .rstN(rstN), .usStrobe(usStrobe), .resSel(resSel),
    .srcSel(srcSel), .extTagClk(extTagClk), .swStep(swStep),
    .swClear(swClear), .hostWrEn(hostWrEn), .hostWrData(hostWrData),
    .syncClrEn(syncClrEn), .syncLdEn(syncLdEn), .syncNoData(syncNoData),
    .syncWithData(syncWithData), .syncData(syncData),
    .somStrobe(somStrobe), .eomStrobe(eomStrobe), .rollAck(rollAck),
    .rollIrqEn(rollIrqEn), .tagValue(tagValue), .snapValue(snapValue),
    .rollFlag(rollFlag), .rollIrq(rollIrq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic doClear();
    tick(); swClear = 1;
    tick(); swClear = 0;
  endtask

  task automatic hostWrite(input logic [15:0] v);
    tick(); hostWrEn = 1; hostWrData = v;
    tick(); hostWrEn = 0;
  endtask

  task automatic usPulses(input int n);
    for (int i = 0; i < n; i++) begin
      tick(); usStrobe = 1;
      tick(); usStrobe = 0;
    end
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) begin
      tick(); swStep = 1;
      tick(); swStep = 0;
    end
  endtask

  task automatic extPulses(input int n);
    for (int i = 0; i < n; i++) begin
      tick(); extTagClk = 1;
      repeat (4) tick();
      extTagClk = 0;
      repeat (4) tick();
    end
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rstN = 1;
    tick();
    // R1 reset state
    check("R1 tag", tagValue, 16'h0);
    check("R1 snap", snapValue, 16'h0);
    check("R1 flag", {15'd0, rollFlag}, 16'h0);
    check("R1 irq", {15'd0, rollIrq}, 16'h0);

    // R2 resolution table, internal timebase
    srcSel = 2'd0;
    for (int v = 0; v < 8; v++) begin
      doClear();
      resSel = VEC[v][26:24];
      usPulses(int'(VEC[v][23:16]));
      tick();
      check($sformatf("R2 sel%0d", VEC[v][26:24]), tagValue, VEC[v][15:0]);
    end

    // R5 host write beats a tick in the same cycle
    resSel = 3'd0; doClear();
    usPulses(1);
    tick(); usStrobe = 1; hostWrEn = 1; hostWrData = 16'h0100;
    tick(); usStrobe = 0; hostWrEn = 0;
    check("R5 write over tick", tagValue, 16'h0100);
    hostWrite(16'h1234);
    check("R5 write", tagValue, 16'h1234);

    // R3 step mode
    srcSel = 2'd2; hostWrite(16'h0010);
    steps(3);
    check("R3 steps", tagValue, 16'h0013);
    usPulses(4);
    check("R3 us ignored", tagValue, 16'h0013);
    srcSel = 2'd0; resSel = 3'd5;
    steps(2);
    check("R3 step ignored internal", tagValue, 16'h0013);

    // R4 external clock
    srcSel = 2'd1; hostWrite(16'h0000);
    extPulses(2);
    check("R4 ext edges", tagValue, 16'h0002);
    usPulses(10); steps(2);
    check("R4 us ignored", tagValue, 16'h0002);
    tick(); extTagClk = 1;
    tick(); tick();
    check("R4 latency before", tagValue, 16'h0002);
    tick();
    check("R4 latency after", tagValue, 16'h0003);
    extTagClk = 0; repeat (4) tick();

    // R6 sync clear
    srcSel = 2'd2; hostWrite(16'h0055);
    tick(); syncNoData = 1; tick(); syncNoData = 0;
    check("R6 disabled", tagValue, 16'h0055);
    syncClrEn = 1;
    tick(); syncNoData = 1; tick(); syncNoData = 0;
    check("R6 clear", tagValue, 16'h0000);

    // R7 sync load beats host write
    tick(); syncWithData = 1; syncData = 16'hBEEF; hostWrEn = 1; hostWrData = 16'h1111;
    tick(); syncWithData = 0; hostWrEn = 0;
    check("R7 disabled", tagValue, 16'h1111);
    syncLdEn = 1;
    tick(); syncWithData = 1; syncData = 16'hBEEF; hostWrEn = 1; hostWrData = 16'h2222;
    tick(); syncWithData = 0; hostWrEn = 0;
    check("R7 load over write", tagValue, 16'hBEEF);

    // R8 rollover
    hostWrite(16'hFFFF);
    check("R8 write no flag", {15'd0, rollFlag}, 16'h0);
    steps(1);
    check("R8 wrap", tagValue, 16'h0000);
    check("R8 flag", {15'd0, rollFlag}, 16'h1);
    check("R8 irq masked", {15'd0, rollIrq}, 16'h0);
    rollIrqEn = 1; tick();
    check("R8 irq", {15'd0, rollIrq}, 16'h1);
    steps(2);
    check("R8 sticky", {15'd0, rollFlag}, 16'h1);
    tick(); rollAck = 1; tick(); rollAck = 0;
    check("R8 ack", {15'd0, rollFlag}, 16'h0);
    hostWrite(16'hFFFF);
    tick(); swStep = 1; rollAck = 1;
    tick(); swStep = 0; rollAck = 0;
    check("R8 set over ack", {15'd0, rollFlag}, 16'h1);

    // R9 snapshots
    hostWrite(16'h0042);
    tick(); somStrobe = 1; tick(); somStrobe = 0;
    check("R9 som", snapValue, 16'h0042);
    hostWrite(16'h0077);
    tick(); eomStrobe = 1; tick(); eomStrobe = 0;
    check("R9 eom", snapValue, 16'h0077);
    hostWrite(16'h0005);
    tick(); somStrobe = 1; swStep = 1;
    tick(); somStrobe = 0; swStep = 0;
    check("R9 pre-update snap", snapValue, 16'h0005);
    check("R9 tag after", tagValue, 16'h0006);

    // R10 reset command priority
    tick(); swClear = 1; syncWithData = 1; syncData = 16'h4444; hostWrEn = 1; hostWrData = 16'h3333;
    tick(); swClear = 0; syncWithData = 0; hostWrEn = 0;
    check("R10 clear priority", tagValue, 16'h0000);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule